// File: doc/BRIEF.md
# Pin Flag Interrupt Detector

This block serves sixteen general-purpose pins. Every input pin passes through a two-flop synchronizer and one more sampling register. The sampled pin states can be read back. Each pin is set to either level or edge sensitivity. An edge-sensitive pin fires on one chosen edge, or on both edges when its dual-edge bit is set. A level-sensitive pin raises its request for as long as the pin is active, and its dual-edge bit does nothing. Edge events are held in a pending register until software writes a one to that pin's bit. A mask register decides which per-pin requests reach the single interrupt output.

A pin can also be driven as an output. Its output value passes through a pacer that lets the pin toggle at most once per fixed interval. A write that lands inside the interval is held and takes effect when the interval ends. Software reaches all of this through a flat three-bit register select with a write strobe and a combinational read path.

Top module: `gpio_flag_irq`

## Requirements
- R1: When a pin is edge-sensitive and its dual-edge bit is 1, both a rising and a falling pin transition set that pin's pending flag and raise the interrupt.
- R2: While reset is applied and right after it, every register reads 0, the interrupt output is 0 and all pin outputs and output enables are 0.
- R3: The dual-edge bit has no effect on a level-sensitive pin. Such a pin's request follows the pin's level and leaves nothing latched after the pin returns inactive.
- R4: A pin change made just before clock edge N reads as changed in the pin state register (select 7) from edge N+3, and not at edge N+2.
- R5: For an unmasked level-sensitive pin, the interrupt output is 1 from edge N+4 when the pin becomes active before edge N, and 0 from edge N+4 when the pin becomes inactive before edge N.
- R6: For an edge-sensitive pin, a qualifying edge before clock edge N raises the interrupt at edge N+5, and not earlier. The pending flag (read at select 6) stays set until a one is written to its bit at select 6. The interrupt then drops one cycle after the write edge.
- R7: The polarity bit chooses the active state of a pin. Polarity 0 means active-high for a level pin and the rising edge for an edge pin. Polarity 1 means active-low and the falling edge. With polarity 1, a single-edge pin ignores a rising edge.
- R8: The interrupt output is the OR of all requests whose mask bit is 1. A masked pin does not raise it, and unmasking a pin whose request is already active raises it one cycle after the write edge.
- R9: A pin set as an output changes at most once every 4 clock cycles. A value written at edge W appears at edge W+1. A different value written at edge W+1 appears at edge W+5.
- R10: Registers are selected by the three-bit select: 0 direction (1 = output), 1 output value, 2 sensitivity (1 = edge), 3 dual-edge, 4 polarity, 5 mask, 6 pending (write one to clear), 7 pin state (read only). Values written to selects 0 to 5 read back unchanged, and the direction register drives the output enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in_i | input | 16 | Asynchronous pin levels |
| pin_out_o | output | 16 | Paced output values |
| pin_oe_o | output | 16 | Output enables, one per pin |
| reg_sel_i | input | 3 | Register select |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 16 | Write data |
| rd_data_o | output | 16 | Read data for the selected register |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The detector is driven with isolated rising and falling transitions on single pins, each under a different combination of sensitivity, polarity and dual-edge setting. Each result shows whether the event is judged by level, by the chosen edge, or by either edge. Latency is checked one cycle before and at the expected edge, which pins down the three-, four- and five-cycle paths separately. Masked versus unmasked active requests show the gating at the output. Back-to-back output writes show whether the second value is dropped, applied early or correctly deferred.

// File: rtl/gpio_flag_pkg.sv
`timescale 1ns/1ps
package gpio_flag_pkg;
  typedef enum logic [2:0] {
    RS_DIR   = 3'd0,
    RS_OUT   = 3'd1,
    RS_SENSE = 3'd2,
    RS_BOTH  = 3'd3,
    RS_POLAR = 3'd4,
    RS_MASK  = 3'd5,
    RS_PEND  = 3'd6,
    RS_PINS  = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/gpio_in_sync.sv
`timescale 1ns/1ps
// Two-flop synchronizer, one sampling stage, and a previous-sample stage.
module gpio_in_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] state_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] meta_q, sync_q, samp_q, prev_q;
  logic [W-1:0] meta_d, sync_d, samp_d, prev_d;

  always_comb begin
    meta_d = pin_i;
    sync_d = meta_q;
    samp_d = sync_q;
    prev_d = samp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      samp_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= meta_d;
      sync_q <= sync_d;
      samp_q <= samp_d;
      prev_q <= prev_d;
    end
  end

  assign state_o = samp_q;
  assign prev_o  = prev_q;
endmodule

// File: rtl/gpio_irq_core.sv
`timescale 1ns/1ps
// Per-pin edge/level qualification, pending latch, mask and combine.
module gpio_irq_core #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] state_i,
  input  logic [W-1:0] prev_i,
  input  logic [W-1:0] sense_i,
  input  logic [W-1:0] both_i,
  input  logic [W-1:0] polar_i,
  input  logic [W-1:0] mask_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] pend_o,
  output logic         irq_o
);
  logic [W-1:0] pend_q, pend_d;
  logic         irq_q, irq_d;
  logic [W-1:0] rise, fall, hit, level_req, req;

  always_comb begin
    rise      = state_i & ~prev_i;
    fall      = ~state_i & prev_i;
    for (int i = 0; i < W; i++) begin
      if (both_i[i]) hit[i] = rise[i] | fall[i];
      else           hit[i] = polar_i[i] ? fall[i] : rise[i];
    end
    level_req = state_i ^ polar_i;
    // a new event in the same cycle as a clear is kept
    pend_d    = (pend_q & ~clr_i) | (hit & sense_i);
    for (int i = 0; i < W; i++) begin
      req[i] = sense_i[i] ? pend_q[i] : level_req[i];
    end
    irq_d     = |(req & mask_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      irq_q  <= irq_d;
    end
  end

  assign pend_o = pend_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/gpio_out_pacer.sv
`timescale 1ns/1ps
// Limits each output pin to one transition per GAP cycles; the latest
// requested value is applied as soon as the interval has run out.
module gpio_out_pacer #(
  parameter int W   = 16,
  parameter int GAP = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] want_i,
  output logic [W-1:0] pin_o
);
  localparam int CW = (GAP > 1) ? $clog2(GAP) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(GAP - 1);

  for (genvar g = 0; g < W; g++) begin : g_pin
    logic          out_q, out_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          idle, change;

    always_comb begin
      idle   = (cnt_q == '0);
      change = idle && (want_i[g] != out_q);
      out_d  = change ? want_i[g] : out_q;
      if (change)     cnt_d = RELOAD;
      else if (!idle) cnt_d = cnt_q - 1'b1;
      else            cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        out_q <= 1'b0;
        cnt_q <= '0;
      end else begin
        out_q <= out_d;
        cnt_q <= cnt_d;
      end
    end

    assign pin_o[g] = out_q;
  end
endmodule

// File: rtl/gpio_flag_irq.sv
`timescale 1ns/1ps
module gpio_flag_irq
  import gpio_flag_pkg::*;
#(
  parameter int NPINS   = 16,
  parameter int OUT_GAP = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_in_i,
  output logic [NPINS-1:0] pin_out_o,
  output logic [NPINS-1:0] pin_oe_o,
  input  logic [2:0]       reg_sel_i,
  input  logic             wr_en_i,
  input  logic [NPINS-1:0] wr_data_i,
  output logic [NPINS-1:0] rd_data_o,
  output logic             irq_o
);
  reg_sel_e sel;
  assign sel = reg_sel_e'(reg_sel_i);

  logic [NPINS-1:0] dir_q, want_q, sense_q, both_q, polar_q, mask_q;
  logic [NPINS-1:0] dir_d, want_d, sense_d, both_d, polar_d, mask_d;
  logic [NPINS-1:0] clr_strobe;
  logic [NPINS-1:0] pin_state, pin_prev, pend;

  always_comb begin
    dir_d      = dir_q;
    want_d     = want_q;
    sense_d    = sense_q;
    both_d     = both_q;
    polar_d    = polar_q;
    mask_d     = mask_q;
    clr_strobe = '0;
    if (wr_en_i) begin
      unique case (sel)
        RS_DIR:   dir_d      = wr_data_i;
        RS_OUT:   want_d     = wr_data_i;
        RS_SENSE: sense_d    = wr_data_i;
        RS_BOTH:  both_d     = wr_data_i;
        RS_POLAR: polar_d    = wr_data_i;
        RS_MASK:  mask_d     = wr_data_i;
        RS_PEND:  clr_strobe = wr_data_i;
        RS_PINS:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '0;
      want_q  <= '0;
      sense_q <= '0;
      both_q  <= '0;
      polar_q <= '0;
      mask_q  <= '0;
    end else begin
      dir_q   <= dir_d;
      want_q  <= want_d;
      sense_q <= sense_d;
      both_q  <= both_d;
      polar_q <= polar_d;
      mask_q  <= mask_d;
    end
  end

  always_comb begin
    unique case (sel)
      RS_DIR:   rd_data_o = dir_q;
      RS_OUT:   rd_data_o = want_q;
      RS_SENSE: rd_data_o = sense_q;
      RS_BOTH:  rd_data_o = both_q;
      RS_POLAR: rd_data_o = polar_q;
      RS_MASK:  rd_data_o = mask_q;
      RS_PEND:  rd_data_o = pend;
      RS_PINS:  rd_data_o = pin_state;
    endcase
  end

  gpio_in_sync #(.W(NPINS)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_i   (pin_in_i),
    .state_o (pin_state),
    .prev_o  (pin_prev)
  );

  gpio_irq_core #(.W(NPINS)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .state_i (pin_state),
    .prev_i  (pin_prev),
    .sense_i (sense_q),
    .both_i  (both_q),
    .polar_i (polar_q),
    .mask_i  (mask_q),
    .clr_i   (clr_strobe),
    .pend_o  (pend),
    .irq_o   (irq_o)
  );

  gpio_out_pacer #(.W(NPINS), .GAP(OUT_GAP)) u_pacer (
    .clk    (clk),
    .rst_n  (rst_n),
    .want_i (want_q),
    .pin_o  (pin_out_o)
  );

  assign pin_oe_o = dir_q;
endmodule

// File: rtl/gpio_flag_irq_chk.sv
`timescale 1ns/1ps
module gpio_flag_irq_chk #(
  parameter int NPINS   = 16,
  parameter int OUT_GAP = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPINS-1:0] pin_in,
  input logic [NPINS-1:0] pin_state,
  input logic [NPINS-1:0] sense,
  input logic [NPINS-1:0] polar,
  input logic [NPINS-1:0] mask,
  input logic [NPINS-1:0] pend,
  input logic [NPINS-1:0] clr,
  input logic             irq,
  input logic [NPINS-1:0] pin_out
);
  localparam int GW = (OUT_GAP > 1) ? $clog2(OUT_GAP) + 1 : 2;
  localparam logic [GW-1:0] GAP_MIN = GW'(OUT_GAP - 1);

  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R2: assert (irq == 1'b0 && pin_out == '0);
    end
  end

  // R4: readable state is the pin sampled three edges earlier
  assert_sync_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd3) |-> (pin_state == $past(pin_in, 3)));

  // R5: an active unmasked level pin raises the interrupt on the next edge
  assert_level_raise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|(~sense & mask & (pin_state ^ polar))) |=> irq);

  // R6: a pending flag only drops after a clear write to its bit
  assert_pend_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q != 2'd0) |-> ((~pend & $past(pend & ~clr)) == '0));

  // R8: no enabled pin means no interrupt
  assert_mask_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |=> !irq);

  for (genvar g = 0; g < NPINS; g++) begin : g_pace
    logic          prev_q;
    logic [GW-1:0] gap_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q <= 1'b0;
        gap_q  <= GAP_MIN;
      end else begin
        prev_q <= pin_out[g];
        if (pin_out[g] != prev_q) gap_q <= '0;
        else if (gap_q < GAP_MIN) gap_q <= gap_q + 1'b1;
      end
    end
    // R9: output transitions at least OUT_GAP cycles apart
    assert_out_spacing_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_out[g] != prev_q) |-> (gap_q >= GAP_MIN));
  end
endmodule

bind gpio_flag_irq gpio_flag_irq_chk #(.NPINS(NPINS), .OUT_GAP(OUT_GAP)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pin_in    (pin_in_i),
  .pin_state (pin_state),
  .sense     (sense_q),
  .polar     (polar_q),
  .mask      (mask_q),
  .pend      (pend),
  .clr       (clr_strobe),
  .irq       (irq_o),
  .pin_out   (pin_out_o)
);

// File: tb/tb_gpio_flag_irq.sv
`timescale 1ns/1ps
module tb_gpio_flag_irq;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;
  localparam int K_IRQ = 0, K_OUT = 1, K_RD = 2;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] pin_in, pin_out, pin_oe, wr_data, rd_data;
  logic [2:0]   reg_sel;
  logic         wr_en, irq;

  int cyc = 0;
  int total = 0;
  int bad = 0;
  bit ended = 1'b0;

  typedef struct {
    int    at;
    int    kind;
    int    idx;
    logic  val;
    string tag;
  } item_t;
  item_t sb[$];

  gpio_flag_irq dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_in_i  (pin_in),
    .pin_out_o (pin_out),
    .pin_oe_o  (pin_oe),
    .reg_sel_i (reg_sel),
    .wr_en_i   (wr_en),
    .wr_data_i (wr_data),
    .rd_data_o (rd_data),
    .irq_o     (irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string tag, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s at cycle %0d: actual=%0h expected=%0h", tag, what, cyc, act, exp);
    end
  endtask

  task automatic push(int at, int kind, int idx, logic val, string tag);
    item_t it;
    it.at = at; it.kind = kind; it.idx = idx; it.val = val; it.tag = tag;
    sb.push_back(it);
  endtask

  // monitor: pops scoreboard items due in this cycle
  initial begin
    forever begin
      @(negedge clk);
      #1;
      for (int i = sb.size() - 1; i >= 0; i--) begin
        if (sb[i].at == cyc) begin
          logic act;
          case (sb[i].kind)
            K_IRQ:   act = irq;
            K_OUT:   act = pin_out[sb[i].idx];
            default: act = rd_data[sb[i].idx];
          endcase
          check(act === sb[i].val, sb[i].tag, "scoreboard", int'(act), int'(sb[i].val));
          sb.delete(i);
        end
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [2:0] sel, logic [N-1:0] d);
    @(negedge clk);
    reg_sel = sel; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; reg_sel = 3'd7;
  endtask

  task automatic rd_check(logic [2:0] sel, logic [N-1:0] exp, string tag);
    @(negedge clk);
    reg_sel = sel;
    #1;
    check(rd_data === exp, tag, "register read", int'(rd_data), int'(exp));
    reg_sel = 3'd7;
  endtask

  task automatic set_pin(int p, logic v, output int at);
    @(negedge clk);
    at = cyc;
    pin_in[p] = v;
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "WATCHDOG", "timeout", 0, 1);
    finish_run();
  end

  initial begin
    int n;
    rst_n = 1'b0; pin_in = '0; wr_en = 1'b0; reg_sel = 3'd7; wr_data = '0;
    idle(3);
    #1;
    check(irq === 1'b0, "R2", "irq in reset", int'(irq), 0);
    rst_n = 1'b1;
    idle(1);
    #1;
    check(irq === 1'b0, "R2", "irq after reset", int'(irq), 0);
    check(pin_out === '0, "R2", "pin_out after reset", int'(pin_out), 0);
    check(pin_oe === '0, "R2", "pin_oe after reset", int'(pin_oe), 0);
    for (int s = 0; s < 8; s++) rd_check(3'(s), '0, "R2");

    // configuration; R10 read-back
    wr(3'd5, 16'hFFFF);
    wr(3'd2, 16'h001C);
    wr(3'd4, 16'h0008);
    wr(3'd3, 16'h0012);
    rd_check(3'd5, 16'hFFFF, "R10");
    rd_check(3'd2, 16'h001C, "R10");
    rd_check(3'd4, 16'h0008, "R10");
    rd_check(3'd3, 16'h0012, "R10");
    idle(2);

    // R4 / R5: level pin 0
    set_pin(0, 1'b1, n);
    push(n + 2, K_RD, 0, 1'b0, "R4");
    push(n + 3, K_RD, 0, 1'b1, "R4");
    push(n + 3, K_IRQ, 0, 1'b0, "R5");
    push(n + 4, K_IRQ, 0, 1'b1, "R5");
    idle(6);
    set_pin(0, 1'b0, n);
    push(n + 2, K_RD, 0, 1'b1, "R4");
    push(n + 3, K_RD, 0, 1'b0, "R4");
    push(n + 3, K_IRQ, 0, 1'b1, "R5");
    push(n + 4, K_IRQ, 0, 1'b0, "R5");
    idle(6);

    // R3: level pin 1 with dual-edge bit set
    set_pin(1, 1'b1, n);
    push(n + 4, K_IRQ, 0, 1'b1, "R3");
    idle(6);
    set_pin(1, 1'b0, n);
    push(n + 4, K_IRQ, 0, 1'b0, "R3");
    push(n + 5, K_IRQ, 0, 1'b0, "R3");
    push(n + 8, K_IRQ, 0, 1'b0, "R3");
    idle(9);

    // R6: rising edge on pin 2, latched until cleared
    set_pin(2, 1'b1, n);
    push(n + 4, K_IRQ, 0, 1'b0, "R6");
    push(n + 5, K_IRQ, 0, 1'b1, "R6");
    idle(6);
    set_pin(2, 1'b0, n);
    push(n + 5, K_IRQ, 0, 1'b1, "R6");
    push(n + 8, K_IRQ, 0, 1'b1, "R6");
    idle(9);
    rd_check(3'd6, 16'h0004, "R6");
    wr(3'd6, 16'h0004);
    push(cyc + 1, K_IRQ, 0, 1'b0, "R6");
    idle(3);
    rd_check(3'd6, 16'h0000, "R6");

    // R7: pin 3 falling-edge polarity
    set_pin(3, 1'b1, n);
    push(n + 5, K_IRQ, 0, 1'b0, "R7");
    push(n + 7, K_IRQ, 0, 1'b0, "R7");
    idle(8);
    set_pin(3, 1'b0, n);
    push(n + 4, K_IRQ, 0, 1'b0, "R7");
    push(n + 5, K_IRQ, 0, 1'b1, "R7");
    idle(7);
    wr(3'd6, 16'h0008);
    push(cyc + 1, K_IRQ, 0, 1'b0, "R7");
    idle(3);

    // R1: pin 4 both edges
    set_pin(4, 1'b1, n);
    push(n + 4, K_IRQ, 0, 1'b0, "R1");
    push(n + 5, K_IRQ, 0, 1'b1, "R1");
    idle(7);
    wr(3'd6, 16'h0010);
    push(cyc + 1, K_IRQ, 0, 1'b0, "R1");
    idle(3);
    set_pin(4, 1'b0, n);
    push(n + 4, K_IRQ, 0, 1'b0, "R1");
    push(n + 5, K_IRQ, 0, 1'b1, "R1");
    idle(7);
    rd_check(3'd6, 16'h0010, "R1");
    wr(3'd6, 16'h0010);
    push(cyc + 1, K_IRQ, 0, 1'b0, "R1");
    idle(3);

    // R8: masking of level pin 5
    wr(3'd5, 16'hFFDF);
    set_pin(5, 1'b1, n);
    push(n + 4, K_IRQ, 0, 1'b0, "R8");
    push(n + 8, K_IRQ, 0, 1'b0, "R8");
    idle(9);
    wr(3'd5, 16'hFFFF);
    push(cyc + 1, K_IRQ, 0, 1'b1, "R8");
    idle(3);
    set_pin(5, 1'b0, n);
    push(n + 4, K_IRQ, 0, 1'b0, "R8");
    idle(6);

    // R9: output pacing on pin 6
    wr(3'd0, 16'h0040);
    #1;
    check(pin_oe === 16'h0040, "R10", "pin_oe from direction", int'(pin_oe), 'h40);
    wr(3'd1, 16'h0040);
    n = cyc;
    push(n + 1, K_OUT, 6, 1'b1, "R9");
    push(n + 4, K_OUT, 6, 1'b1, "R9");
    push(n + 5, K_OUT, 6, 1'b0, "R9");
    push(n + 6, K_OUT, 6, 1'b0, "R9");
    wr(3'd1, 16'h0000);
    idle(8);

    check(sb.size() == 0, "SB", "unconsumed items", sb.size(), 0);
    finish_run();
  end
endmodule